// File: doc/BRIEF.md
# Lane Synchronization Controller

This block is the receive-side link state machine for one lane of a multi-gigabit converter link. It accepts one already-decoded character per beat (eight data bits, a control flag and a decode-error flag). It holds the active-low synchronization request low while it hunts for the comma character. Once it has locked, it releases the request and follows the four-multiframe alignment preamble that the transmitter sends. It then hands user data downstream.

While it follows the preamble, it emits a one-cycle marker on the first start-of-multiframe character, so that a lane aligner downstream can use that point. It shows when the configuration multiframe is in flight, and it captures the fourteen parameter bytes of that multiframe into a register bank. Any decode error, or any control character that does not belong where it appears, sends the lane back to the hunt with the request asserted again.

The input side is a stream qualified by `in_valid` and has no ready signal. The block takes a character on every cycle in which `in_valid` is high and never applies back-pressure. A cycle with `in_valid` low is a bubble: no state moves. The output side is a stream qualified by `out_valid` and also has no ready signal. The consumer must take every beat in the cycle it is presented. The other outputs are plain status levels and pulses.

Top module: `lane_sync_ctrl`

## Requirements
- R1: Control characters carry `in_is_k`=1 with these codes: comma 0xBC, multiframe start 0x1C, multiframe end 0x7C, configuration marker 0x9C, frame end 0xFC. After reset, `sync_n` is 0 and `link_ready`, `ilas_start`, `cfg_phase` and `out_valid` are 0.
- R2: In the hunt, `sync_n` goes to 1 in the cycle after the fourth consecutive accepted error-free comma. Any other accepted character restarts the count.
- R3: After lock, accepted commas keep the lane waiting. The first accepted 0x1C makes `ilas_start` high for exactly the next cycle. Any other accepted character returns the lane to the hunt.
- R4: The preamble is four multiframes of FRAMES_PER_MF*OCTETS_PER_FRAME characters each. Position 0 of each must be 0x1C and the last position must be 0x7C. The other positions must be data characters, except as R5 states. A violation sets `sync_n` to 0 in the next cycle.
- R5: In the second multiframe, position 1 must be 0x9C. Positions 2 to 15 are stored, and position 2+i lands in `cfg_bytes[8i+7:8i]`. `cfg_phase` is high from the cycle after the first multiframe's last character through the cycle in which the second multiframe's last character is accepted.
- R6: One cycle after the first accepted character that follows the fourth multiframe, `link_ready` rises together with `out_valid` and that character. From then on, each accepted character appears as a beat one cycle later.
- R7: During user data, 0x7C and 0xFC control characters pass through as beats with `out_is_k`=1. Any other control character produces no beat and returns the lane to the hunt.
- R8: An accepted character with `in_err`=1 returns the lane to the hunt in the next cycle, whatever the state, with `link_ready` and `out_valid` at 0. This takes priority even over the fourth comma or the first user character.
- R9: While `in_valid` is 0, no state advances, no pulse or beat is produced, and `sync_n` and `link_ready` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character present this cycle |
| in_data | input | 8 | Decoded character byte |
| in_is_k | input | 1 | Character is a control character |
| in_err | input | 1 | Decoder reported an error on this character |
| sync_n | output | 1 | Active-low synchronization request |
| ilas_start | output | 1 | One-cycle marker after the first start-of-multiframe |
| cfg_phase | output | 1 | Configuration multiframe in progress |
| cfg_bytes | output | 112 | Captured configuration bytes, byte i at bits 8i+7:8i |
| link_ready | output | 1 | User data is flowing |
| out_valid | output | 1 | User data beat present |
| out_data | output | 8 | User data byte |
| out_is_k | output | 1 | Beat is a replacement control character |

## Verification
Two functions can land on the same character: lock declaration and error abort when the fourth comma carries the error flag, and the rise of `link_ready` and an abort when the first user character carries it. The bench drives both coincidences on purpose. A behavioural model, updated per accepted character, predicts every output on each clock. `sync_n` must stay low in the first case, and in the second case `link_ready` must never rise and no beat may appear.

// File: rtl/lane_sync_pkg.sv
package lane_sync_pkg;
  localparam logic [7:0] CH_COMMA = 8'hBC;
  localparam logic [7:0] CH_MFBEG = 8'h1C;
  localparam logic [7:0] CH_MFEND = 8'h7C;
  localparam logic [7:0] CH_CFGMK = 8'h9C;
  localparam logic [7:0] CH_FREND = 8'hFC;
  localparam int CFG_BYTES = 14;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ALIGN = 2'd2,
    ST_DATA  = 2'd3
  } lane_state_t;
endpackage

// File: rtl/lane_sync_kcount.sv
// Counts consecutive clean commas during the hunt.
module lane_sync_kcount #(
  parameter int K_NEED = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic hit,
  output logic at_last
);
  localparam int CW = (K_NEED > 1) ? $clog2(K_NEED) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (hit)        cnt <= cnt + CW'(1);
  end

  assign at_last = (cnt == CW'(K_NEED - 1));
endmodule

// File: rtl/lane_sync_mfpos.sv
// Position inside the current multiframe and index of the multiframe.
module lane_sync_mfpos #(
  parameter int MF_LEN  = 32,
  parameter int MF_NUM  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step,
  output logic [$clog2(MF_LEN)-1:0] pos,
  output logic [$clog2(MF_NUM)-1:0] mf,
  output logic pos_last,
  output logic mf_last
);
  localparam int PW = $clog2(MF_LEN);
  localparam int MW = $clog2(MF_NUM);

  assign pos_last = (pos == PW'(MF_LEN - 1));
  assign mf_last  = (mf == MW'(MF_NUM - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      mf  <= '0;
    end else if (start) begin
      pos <= PW'(1);
      mf  <= '0;
    end else if (step) begin
      if (pos_last) begin
        pos <= '0;
        mf  <= mf + MW'(1);
      end else begin
        pos <= pos + PW'(1);
      end
    end
  end
endmodule

// File: rtl/lane_sync_cfgbank.sv
// Byte-addressed capture bank for the configuration parameters.
module lane_sync_cfgbank #(
  parameter int NBYTES = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic [$clog2(NBYTES)-1:0] idx,
  input  logic [7:0] din,
  output logic [NBYTES*8-1:0] bytes_o
);
  localparam int IW = $clog2(NBYTES);

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                        bytes_o[8*i +: 8] <= '0;
      else if (we && idx == IW'(i))      bytes_o[8*i +: 8] <= din;
    end
  end
endmodule

// File: rtl/lane_sync_ctrl.sv
module lane_sync_ctrl
  import lane_sync_pkg::*;
#(
  parameter int FRAMES_PER_MF    = 8,
  parameter int OCTETS_PER_FRAME = 4,
  parameter int K_NEED           = 4,
  parameter int ILAS_MFS         = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  input  logic                   in_is_k,
  input  logic                   in_err,
  output logic                   sync_n,
  output logic                   ilas_start,
  output logic                   cfg_phase,
  output logic [CFG_BYTES*8-1:0] cfg_bytes,
  output logic                   link_ready,
  output logic                   out_valid,
  output logic [7:0]             out_data,
  output logic                   out_is_k
);
  localparam int MF_LEN = FRAMES_PER_MF * OCTETS_PER_FRAME;
  localparam int PW     = $clog2(MF_LEN);
  localparam int MW     = $clog2(ILAS_MFS);
  localparam int CIW    = $clog2(CFG_BYTES);

  lane_state_t st, st_nx;

  logic is_comma, is_beg, is_end, is_cfg, is_frend;
  assign is_comma = in_is_k && (in_data == CH_COMMA);
  assign is_beg   = in_is_k && (in_data == CH_MFBEG);
  assign is_end   = in_is_k && (in_data == CH_MFEND);
  assign is_cfg   = in_is_k && (in_data == CH_CFGMK);
  assign is_frend = in_is_k && (in_data == CH_FREND);

  logic k_hit, k_clear, k_last;
  logic mf_start, mf_step, pos_last, mf_last;
  logic [PW-1:0] pos;
  logic [MW-1:0] mf;
  logic align_ok, beat, go_hunt, cap_we;

  lane_sync_kcount #(.K_NEED(K_NEED)) u_kcount (
    .clk(clk), .rst_n(rst_n), .clear(k_clear), .hit(k_hit), .at_last(k_last)
  );

  lane_sync_mfpos #(.MF_LEN(MF_LEN), .MF_NUM(ILAS_MFS)) u_mfpos (
    .clk(clk), .rst_n(rst_n), .start(mf_start), .step(mf_step),
    .pos(pos), .mf(mf), .pos_last(pos_last), .mf_last(mf_last)
  );

  // Expected character class for the current preamble position
  always_comb begin
    if (pos == '0)                                align_ok = is_beg;
    else if (pos_last)                            align_ok = is_end;
    else if (mf == MW'(1) && pos == PW'(1))       align_ok = is_cfg;
    else                                          align_ok = !in_is_k;
  end

  always_comb begin
    st_nx    = st;
    k_hit    = 1'b0;
    mf_start = 1'b0;
    mf_step  = 1'b0;
    beat     = 1'b0;
    go_hunt  = 1'b0;
    if (in_valid) begin
      unique case (st)
        ST_HUNT: begin
          if (!in_err && is_comma) begin
            k_hit = 1'b1;
            if (k_last) st_nx = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (in_err)          go_hunt = 1'b1;
          else if (is_beg) begin
            mf_start = 1'b1;
            st_nx    = ST_ALIGN;
          end
          else if (!is_comma)  go_hunt = 1'b1;
        end
        ST_ALIGN: begin
          if (in_err || !align_ok) go_hunt = 1'b1;
          else begin
            mf_step = 1'b1;
            if (pos_last && mf_last) st_nx = ST_DATA;
          end
        end
        ST_DATA: begin
          if (in_err || (in_is_k && !is_end && !is_frend)) go_hunt = 1'b1;
          else beat = 1'b1;
        end
        default: go_hunt = 1'b1;
      endcase
    end
    if (go_hunt) st_nx = ST_HUNT;
  end

  assign k_clear = (st != ST_HUNT) || (in_valid && !k_hit);

  assign cap_we = mf_step && (mf == MW'(1)) &&
                  (pos >= PW'(2)) && (pos < PW'(CFG_BYTES + 2));

  lane_sync_cfgbank #(.NBYTES(CFG_BYTES)) u_cfgbank (
    .clk(clk), .rst_n(rst_n), .we(cap_we),
    .idx(CIW'(pos - PW'(2))), .din(in_data), .bytes_o(cfg_bytes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_HUNT;
      ilas_start <= 1'b0;
      link_ready <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_is_k   <= 1'b0;
    end else begin
      st         <= st_nx;
      ilas_start <= mf_start;
      out_valid  <= beat;
      if (go_hunt)   link_ready <= 1'b0;
      else if (beat) link_ready <= 1'b1;
      if (beat) begin
        out_data <= in_data;
        out_is_k <= in_is_k;
      end
    end
  end

  assign sync_n    = (st != ST_HUNT);
  assign cfg_phase = (st == ST_ALIGN) && (mf == MW'(1));
endmodule

// File: rtl/lane_sync_ctrl_chk.sv
module lane_sync_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_is_k,
  input logic       in_err,
  input logic       sync_n,
  input logic       ilas_start,
  input logic       cfg_phase,
  input logic       link_ready,
  input logic       out_valid
);
  assert_lock_on_comma_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> $past(in_valid && !in_err && in_is_k && in_data == 8'hBC));

  assert_marker_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ilas_start |-> (sync_n && $past(in_valid && in_is_k && in_data == 8'h1C)));

  assert_cfg_while_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_phase |-> sync_n);

  assert_beat_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> link_ready);

  assert_ready_with_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> out_valid);

  assert_stray_ctl_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ready && in_valid && in_is_k && in_data != 8'h7C && in_data != 8'hFC)
      |=> !sync_n);

  assert_err_to_hunt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_err) |=> (!sync_n && !link_ready && !out_valid));

  assert_bubble_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sync_n) && $stable(link_ready) && !out_valid && !ilas_start));
endmodule

bind lane_sync_ctrl lane_sync_ctrl_chk u_chk (.*);

// File: tb/lane_sync_ctrl_test.sv
module lane_sync_ctrl_test;
  localparam int L  = 8 * 4;
  localparam int NC = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_is_k = 1'b0;
  logic in_err = 1'b0;
  logic sync_n, ilas_start, cfg_phase, link_ready, out_valid, out_is_k;
  logic [NC*8-1:0] cfg_bytes;
  logic [7:0] out_data;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  lane_sync_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_is_k(in_is_k), .in_err(in_err), .sync_n(sync_n),
    .ilas_start(ilas_start), .cfg_phase(cfg_phase), .cfg_bytes(cfg_bytes),
    .link_ready(link_ready), .out_valid(out_valid), .out_data(out_data),
    .out_is_k(out_is_k)
  );

  // Behavioural reference: 0 hunt, 1 waiting, 2 preamble, 3 user data
  int m_st = 0, m_k = 0, m_pos = 0, m_mf = 0;
  bit m_ready = 0, m_marker = 0, m_ov = 0, m_ok = 0;
  byte unsigned m_od = 0;
  byte unsigned m_cfg [NC];

  function automatic bit ctl(input [7:0] d, input bit k, input [7:0] c);
    return k && d == c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_k = 0; m_pos = 0; m_mf = 0;
      m_ready = 0; m_marker = 0; m_ov = 0; m_ok = 0; m_od = 0;
      foreach (m_cfg[i]) m_cfg[i] = 0;
    end else begin
      bit hunt;
      bit good;
      hunt = 0;
      m_marker = 0;
      m_ov = 0;
      if (in_valid) begin
        case (m_st)
          0: if (!in_err && ctl(in_data, in_is_k, 8'hBC)) begin
               m_k++;
               if (m_k == 4) begin m_st = 1; m_k = 0; end
             end else m_k = 0;
          1: if (in_err) hunt = 1;
             else if (ctl(in_data, in_is_k, 8'h1C)) begin
               m_st = 2; m_pos = 1; m_mf = 0; m_marker = 1;
             end else if (!ctl(in_data, in_is_k, 8'hBC)) hunt = 1;
          2: begin
               if (m_pos == 0)                    good = ctl(in_data, in_is_k, 8'h1C);
               else if (m_pos == L - 1)           good = ctl(in_data, in_is_k, 8'h7C);
               else if (m_mf == 1 && m_pos == 1)  good = ctl(in_data, in_is_k, 8'h9C);
               else                               good = !in_is_k;
               if (in_err || !good) hunt = 1;
               else begin
                 if (m_mf == 1 && m_pos >= 2 && m_pos < 2 + NC) m_cfg[m_pos - 2] = in_data;
                 if (m_pos == L - 1) begin
                   m_pos = 0;
                   if (m_mf == 3) m_st = 3; else m_mf++;
                 end else m_pos++;
               end
             end
          default:
             if (in_err || (in_is_k && in_data != 8'h7C && in_data != 8'hFC)) hunt = 1;
             else begin m_ov = 1; m_od = in_data; m_ok = in_is_k; m_ready = 1; end
        endcase
        if (hunt) begin m_st = 0; m_k = 0; m_ready = 0; end
      end
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("R2", "sync_n", int'(sync_n), int'(m_st != 0));
      cmp("R3", "ilas_start", int'(ilas_start), int'(m_marker));
      cmp("R5", "cfg_phase", int'(cfg_phase), int'(m_st == 2 && m_mf == 1));
      cmp("R6", "link_ready", int'(link_ready), int'(m_ready));
      cmp("R6", "out_valid", int'(out_valid), int'(m_ov));
      if (m_ov) begin
        cmp("R6", "out_data", int'(out_data), int'(m_od));
        cmp("R7", "out_is_k", int'(out_is_k), int'(m_ok));
      end
      for (int i = 0; i < NC; i++)
        cmp("R5", "cfg_byte", int'(cfg_bytes[8*i +: 8]), int'(m_cfg[i]));
    end
  end

  task automatic put(input [7:0] d, input bit k, input bit e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_is_k = k; in_err = e;
  endtask

  task automatic gap(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; in_err = 1'b0;
    end
  endtask

  task automatic commas(input int n);
    for (int i = 0; i < n; i++) put(8'hBC, 1'b1, 1'b0);
  endtask

  // mode 0: clean preamble; mode 1: end of first multiframe not a control char
  task automatic preamble(input int mode, input int seed);
    for (int mf = 0; mf < 4; mf++) begin
      for (int p = 0; p < L; p++) begin
        logic [7:0] d;
        bit k;
        d = 8'(mf * 40 + p + seed); k = 1'b0;
        if (p == 0) begin d = 8'h1C; k = 1'b1; end
        else if (p == L - 1) begin d = 8'h7C; k = 1'b1; end
        else if (mf == 1 && p == 1) begin d = 8'h9C; k = 1'b1; end
        else if (mf == 1 && p >= 2 && p < 2 + NC) d = 8'((p - 2) * 17 + 3 + seed);
        if (mode == 1 && mf == 0 && p == L - 1) k = 1'b0;
        put(d, k, 1'b0);
        if (mode == 1 && mf == 0 && p == L - 1) return;
        if (mf == 2 && p == 5) gap(3);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", "reset sync_n", int'(sync_n), 0);
    cmp("R1", "reset link_ready", int'(link_ready), 0);
    cmp("R1", "reset out_valid", int'(out_valid), 0);
    cmp("R1", "reset ilas_start", int'(ilas_start), 0);
    rst_n = 1'b1;

    // R2: broken run of commas, then a clean run with bubbles (R9)
    commas(3);
    put(8'h55, 1'b0, 1'b0);
    gap(1);
    cmp("R2", "count restarts", int'(sync_n), 0);
    commas(2); gap(2); commas(2);
    gap(1);
    cmp("R2", "lock after four", int'(sync_n), 1);

    // R3 then full preamble with capture (R4, R5) and user data (R6, R7)
    commas(3);
    preamble(0, 0);
    gap(1);
    cmp("R5", "cfg byte 13", int'(cfg_bytes[8*13 +: 8]), 13 * 17 + 3);
    cmp("R6", "ready before data", int'(link_ready), 0);
    put(8'h11, 1'b0, 1'b0);
    gap(1);
    cmp("R6", "first beat ready", int'(link_ready), 1);
    put(8'h22, 1'b0, 1'b0);
    put(8'h7C, 1'b1, 1'b0);
    put(8'hFC, 1'b1, 1'b0);
    gap(1);
    cmp("R7", "frame-end passes", int'(out_is_k), 1);
    put(8'h1C, 1'b1, 1'b0);
    gap(1);
    cmp("R7", "stray control hunts", int'(sync_n), 0);

    // R8: error on the fourth comma keeps the request low
    commas(3);
    put(8'hBC, 1'b1, 1'b1);
    gap(1);
    cmp("R8", "error on fourth comma", int'(sync_n), 0);
    commas(4);

    // R3: stray data while waiting
    put(8'h00, 1'b0, 1'b0);
    gap(1);
    cmp("R3", "stray while waiting", int'(sync_n), 0);

    // R4: bad end of first multiframe
    commas(4);
    preamble(1, 5);
    gap(1);
    cmp("R4", "bad multiframe end", int'(sync_n), 0);

    // R8: error on first user character
    commas(4);
    preamble(0, 9);
    put(8'h33, 1'b0, 1'b1);
    gap(1);
    cmp("R8", "no ready on error", int'(link_ready), 0);
    cmp("R8", "no beat on error", int'(out_valid), 0);

    // R8: error mid data
    commas(4);
    preamble(0, 2);
    put(8'h44, 1'b0, 1'b0);
    put(8'h45, 1'b0, 1'b0);
    put(8'h46, 1'b0, 1'b1);
    gap(2);
    cmp("R8", "error mid data", int'(link_ready), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule